// File: doc/BRIEF.md
# PCI Target Parity Error Reporter

This block sits next to a PCI target's bus interface and checks parity on the shared address/data bus. It checks every address phase on the bus. It also checks every completed data phase in which this device is the selected target. Parity is even over the 32 address/data lines, the four active-low command/byte-enable lines and the parity line. The parity line arrives one clock after the phase it covers, so the block keeps registered copies of the bus for one cycle and compares them against parity on the following edge.

A detected error updates two sticky configuration status bits: a parity-detected flag and a system-error-signalled flag. It can also pulse the active-low data parity error output or the active-low system error output for one clock. Whether those outputs fire depends on two command-register enables held by the surrounding configuration logic. The block never asks the target to stop or disconnect a transfer, so the initiator stays in charge of any recovery. An address that fails parity but still decodes as a hit is claimed and run normally by the target, which is outside this block. Software clears each status flag by writing a one to its bit position.

Top module: `pci_tgt_par_rpt`

## Requirements
- R1: Parity is even. A phase is in error when the XOR of `ad`, `cbe_n` captured at the phase edge and `par` sampled at the next edge is 1.
- R2: A phase is an address phase when `frame_n` is low and both `frame_n` and `irdy_n` were high on the previous edge. A phase is a data phase when it is not an address phase, `irdy_n` and `trdy_n` are both low and `tgt_sel` is high. Parity on any other cycle, including wait states and idle cycles, has no effect.
- R3: An errored data phase sets `stat_det_par` (status bit 15) whatever the state of the enables.
- R4: For an errored data phase, `perr_n` is low only when `cmd_per` (command bit 6) is set. It goes low on the edge where `par` is sampled and stays low for exactly one clock, so it is seen two clocks after the phase. Consecutive errored phases give consecutive low clocks.
- R5: A data phase with `tgt_sel` low produces no `perr_n` pulse and no status change, even with bad parity.
- R6: An errored address phase sets `stat_det_par` whether or not `tgt_sel` is high and whatever the enables are.
- R7: An errored address phase drives `serr_n` low for exactly one clock and sets `stat_sig_serr` (status bit 14) only when both `cmd_per` and `cmd_serr_en` (command bit 8) are set. Otherwise it only sets `stat_det_par`.
- R8: An address error never lowers `perr_n`, and a data error never lowers `serr_n`.
- R9: When `stat_wr` is high, a 1 in `stat_wdata` bit 15 clears `stat_det_par` and a 1 in bit 14 clears `stat_sig_serr`. Zeros and every other bit have no effect.
- R10: A new error and a clear reaching the same status bit on the same edge leave the bit set.
- R11: After reset `perr_n` and `serr_n` are high and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad | input | 32 | Address/data bus |
| cbe_n | input | 4 | Command/byte-enable lines, active low |
| par | input | 1 | Even parity for the previous phase |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| tgt_sel | input | 1 | This device is target of the current transaction |
| cmd_per | input | 1 | Parity error response enable (command bit 6) |
| cmd_serr_en | input | 1 | System error enable (command bit 8) |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 16 | Status write data, bits 15 and 14 write-one-to-clear |
| perr_n | output | 1 | Data parity error, active low |
| serr_n | output | 1 | System error, active low |
| stat_det_par | output | 1 | Status bit 15, parity error detected |
| stat_sig_serr | output | 1 | Status bit 14, system error signalled |

## Verification
A phase presented before edge n is captured at edge n+1, and its parity arrives with edge n+1. Its `perr_n`/`serr_n` pulse and its status updates therefore appear after edge n+2. A status clear presented before edge n takes effect after edge n+1. The driver tags each cycle it drives with the edge count at which that result is due and queues it. The monitor samples at the falling edge and pops only the entry whose due count matches the current count, so every cycle, including the quiet ones, is compared exactly once. Enables change only after two quiet cycles, so no in-flight error sees a changed enable.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

   // Kind of bus phase captured on a clock edge
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_e;

endpackage

// File: rtl/pci_par_xor_tree.sv
module pci_par_xor_tree #(
   parameter int W        = 37,
   parameter bit EXPLICIT = 1'b1
) (
   input  logic [W-1:0] din,
   output logic         odd
);

   localparam int LV = (W > 1) ? $clog2(W) : 0;
   localparam int N  = 1 << LV;

   if (W < 1) begin : g_bad_w
      $error("pci_par_xor_tree: W must be at least 1");
   end

   if (EXPLICIT) begin : g_tree
      for (genvar l = 0; l <= LV; l++) begin : g_lvl
         localparam int CNT = N >> l;
         logic [CNT-1:0] v;
         if (l == 0) begin : g_leaf
            for (genvar j = 0; j < CNT; j++) begin : g_j
               if (j < W) begin : g_in
                  assign v[j] = din[j];
               end else begin : g_pad
                  assign v[j] = 1'b0;
               end
            end
         end else begin : g_node
            for (genvar j = 0; j < CNT; j++) begin : g_j
               assign v[j] = g_lvl[l-1].v[2*j] ^ g_lvl[l-1].v[2*j+1];
            end
         end
      end
      assign odd = g_lvl[LV].v[0];
   end else begin : g_flat
      assign odd = ^din;
   end

endmodule

// File: rtl/pci_par_phase_trk.sv
module pci_par_phase_trk
   import pci_par_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   frame_n,
   input  logic   irdy_n,
   input  logic   trdy_n,
   input  logic   tgt_sel,
   output phase_e kind
);

   logic prev_frame_n;
   logic prev_irdy_n;
   logic is_addr;
   logic is_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_frame_n <= 1'b1;
         prev_irdy_n  <= 1'b1;
      end else begin
         prev_frame_n <= frame_n;
         prev_irdy_n  <= irdy_n;
      end
   end

   // Address phase: frame falls out of a fully idle bus
   assign is_addr = !frame_n && prev_frame_n && prev_irdy_n;
   // Data phase: transfer completes and this device owns it
   assign is_data = !is_addr && !irdy_n && !trdy_n && tgt_sel;

   always_comb begin
      if (is_addr)      kind = PH_ADDR;
      else if (is_data) kind = PH_DATA;
      else              kind = PH_IDLE;
   end

   // R2
   addr_not_repeated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == PH_ADDR) |=> (kind != PH_ADDR));

endmodule

// File: rtl/pci_par_chk_stage.sv
module pci_par_chk_stage
   import pci_par_pkg::*;
#(
   parameter int AD_W          = 32,
   parameter int BE_W          = 4,
   parameter bit TREE_EXPLICIT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AD_W-1:0] ad,
   input  logic [BE_W-1:0] cbe_n,
   input  logic            par,
   input  phase_e          kind,
   output logic            addr_err,
   output logic            data_err
);

   localparam int SUM_W = AD_W + BE_W + 1;

   logic [AD_W-1:0] cap_ad;
   logic [BE_W-1:0] cap_cbe;
   phase_e          cap_kind;
   logic            odd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_ad   <= '0;
         cap_cbe  <= '0;
         cap_kind <= PH_IDLE;
      end else begin
         cap_ad   <= ad;
         cap_cbe  <= cbe_n;
         cap_kind <= kind;
      end
   end

   pci_par_xor_tree #(
      .W        (SUM_W),
      .EXPLICIT (TREE_EXPLICIT)
   ) u_tree (
      .din ({cap_ad, cap_cbe, par}),
      .odd (odd)
   );

   assign addr_err = (cap_kind == PH_ADDR) && odd;
   assign data_err = (cap_kind == PH_DATA) && odd;

   // R2
   addr_err_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |=> !addr_err);

   // R8
   err_kinds_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_err && data_err));

endmodule

// File: rtl/pci_par_report.sv
module pci_par_report #(
   parameter int STAT_W  = 16,
   parameter int DPE_POS = 15,
   parameter int SSE_POS = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_err,
   input  logic              data_err,
   input  logic              cmd_per,
   input  logic              cmd_serr_en,
   input  logic              stat_wr,
   input  logic [STAT_W-1:0] stat_wdata,
   output logic              perr_n,
   output logic              serr_n,
   output logic              stat_det_par,
   output logic              stat_sig_serr
);

   logic dpe_set;
   logic sse_set;
   logic dpe_clr;
   logic sse_clr;
   logic unused_wdata;

   assign dpe_set = addr_err || data_err;
   assign sse_set = addr_err && cmd_per && cmd_serr_en;
   assign dpe_clr = stat_wr && stat_wdata[DPE_POS];
   assign sse_clr = stat_wr && stat_wdata[SSE_POS];
   assign unused_wdata = ^stat_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         perr_n        <= 1'b1;
         serr_n        <= 1'b1;
         stat_det_par  <= 1'b0;
         stat_sig_serr <= 1'b0;
      end else begin
         perr_n        <= !(data_err && cmd_per);
         serr_n        <= !sse_set;
         // a set on the same edge as a clear wins
         stat_det_par  <= dpe_set || (stat_det_par && !dpe_clr);
         stat_sig_serr <= sse_set || (stat_sig_serr && !sse_clr);
      end
   end

   // R4
   perr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n |-> $past(cmd_per));

   // R3
   perr_flags_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n |-> stat_det_par);

   // R7
   serr_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |=> serr_n);

   // R7
   serr_flags_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |-> (stat_sig_serr && stat_det_par));

   // R8
   serr_perr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |-> perr_n);

   // R10
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_err || data_err) |=> stat_det_par);

endmodule

// File: rtl/pci_tgt_par_rpt.sv
module pci_tgt_par_rpt
   import pci_par_pkg::*;
#(
   parameter int AD_W          = 32,
   parameter int STAT_W        = 16,
   parameter int DPE_POS       = 15,
   parameter int SSE_POS       = 14,
   parameter bit TREE_EXPLICIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AD_W-1:0]   ad,
   input  logic [AD_W/8-1:0] cbe_n,
   input  logic              par,
   input  logic              frame_n,
   input  logic              irdy_n,
   input  logic              trdy_n,
   input  logic              tgt_sel,
   input  logic              cmd_per,
   input  logic              cmd_serr_en,
   input  logic              stat_wr,
   input  logic [STAT_W-1:0] stat_wdata,
   output logic              perr_n,
   output logic              serr_n,
   output logic              stat_det_par,
   output logic              stat_sig_serr
);

   localparam int BE_W = AD_W / 8;

   if (AD_W % 8 != 0 || AD_W < 8) begin : g_bad_ad
      $error("pci_tgt_par_rpt: AD_W must be a nonzero multiple of 8");
   end
   if (DPE_POS >= STAT_W || SSE_POS >= STAT_W || DPE_POS == SSE_POS) begin : g_bad_pos
      $error("pci_tgt_par_rpt: status bit positions invalid");
   end

   phase_e kind;
   logic   addr_err;
   logic   data_err;

   pci_par_phase_trk u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .irdy_n  (irdy_n),
      .trdy_n  (trdy_n),
      .tgt_sel (tgt_sel),
      .kind    (kind)
   );

   pci_par_chk_stage #(
      .AD_W          (AD_W),
      .BE_W          (BE_W),
      .TREE_EXPLICIT (TREE_EXPLICIT)
   ) u_chk (
      .clk      (clk),
      .rst_n    (rst_n),
      .ad       (ad),
      .cbe_n    (cbe_n),
      .par      (par),
      .kind     (kind),
      .addr_err (addr_err),
      .data_err (data_err)
   );

   pci_par_report #(
      .STAT_W  (STAT_W),
      .DPE_POS (DPE_POS),
      .SSE_POS (SSE_POS)
   ) u_rep (
      .clk           (clk),
      .rst_n         (rst_n),
      .addr_err      (addr_err),
      .data_err      (data_err),
      .cmd_per       (cmd_per),
      .cmd_serr_en   (cmd_serr_en),
      .stat_wr       (stat_wr),
      .stat_wdata    (stat_wdata),
      .perr_n        (perr_n),
      .serr_n        (serr_n),
      .stat_det_par  (stat_det_par),
      .stat_sig_serr (stat_sig_serr)
   );

endmodule

// File: tb/pci_tgt_par_rpt_tb.sv
`timescale 1ns/1ps
module pci_tgt_par_rpt_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = '0;
   logic        par = 1'b0;
   logic        frame_n = 1'b1;
   logic        irdy_n = 1'b1;
   logic        trdy_n = 1'b1;
   logic        tgt_sel = 1'b0;
   logic        cmd_per = 1'b0;
   logic        cmd_serr_en = 1'b0;
   logic        stat_wr = 1'b0;
   logic [15:0] stat_wdata = '0;
   logic        perr_n;
   logic        serr_n;
   logic        stat_det_par;
   logic        stat_sig_serr;

   pci_tgt_par_rpt u_dut (
      .clk (clk), .rst_n (rst_n), .ad (ad), .cbe_n (cbe_n), .par (par),
      .frame_n (frame_n), .irdy_n (irdy_n), .trdy_n (trdy_n), .tgt_sel (tgt_sel),
      .cmd_per (cmd_per), .cmd_serr_en (cmd_serr_en), .stat_wr (stat_wr),
      .stat_wdata (stat_wdata), .perr_n (perr_n), .serr_n (serr_n),
      .stat_det_par (stat_det_par), .stat_sig_serr (stat_sig_serr)
   );

   always #4 clk = ~clk;

   typedef struct {
      int    due;
      bit    perr_n;
      bit    serr_n;
      bit    dset;
      bit    sset;
      string tag;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    mon_on = 1'b0;
   bit    pend_par = 1'b0;
   bit    pf = 1'b1;
   bit    pi = 1'b1;
   int    clr_edge = -1;
   bit [1:0] clr_m = '0;
   bit    m_dpe = 1'b0;
   bit    m_sse = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: status model (clear then set) and per-cycle comparison
   always @(negedge clk) begin
      if (mon_on) begin
         if (clr_edge == cyc) begin
            if (clr_m[1]) m_dpe = 1'b0;
            if (clr_m[0]) m_sse = 1'b0;
         end
         while (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.dset) m_dpe = 1'b1;
            if (it.sset) m_sse = 1'b1;
            n_chk++;
            if ({perr_n, serr_n, stat_det_par, stat_sig_serr} !==
                {it.perr_n, it.serr_n, m_dpe, m_sse}) begin
               n_fail++;
               $display("FAIL %s cyc %0d: perr_n/serr_n/dpe/sse actual %b%b%b%b expected %b%b%b%b",
                        it.tag, cyc, perr_n, serr_n, stat_det_par, stat_sig_serr,
                        it.perr_n, it.serr_n, m_dpe, m_sse);
            end
         end
      end
   end

   task automatic step(input bit fr, input bit ir, input bit tr, input bit ts,
                       input logic [31:0] a, input logic [3:0] c, input bit bad,
                       input bit we, input logic [15:0] wd, input string tag);
      item_t it;
      bit    is_a;
      bit    is_d;
      @(negedge clk);
      #1;
      par        = pend_par;
      frame_n    = fr;
      irdy_n     = ir;
      trdy_n     = tr;
      tgt_sel    = ts;
      ad         = a;
      cbe_n      = c;
      stat_wr    = we;
      stat_wdata = wd;
      if (we) begin
         clr_edge = cyc + 1;
         clr_m    = {wd[15], wd[14]};
      end
      is_a     = !fr && pf && pi;
      is_d     = !is_a && !ir && !tr && ts;
      pend_par = (^{a, c}) ^ bad;
      pf       = fr;
      pi       = ir;
      it.due    = cyc + 2;
      it.perr_n = !(is_d && bad && cmd_per);
      it.serr_n = !(is_a && bad && cmd_per && cmd_serr_en);
      it.dset   = bad && (is_a || is_d);
      it.sset   = !it.serr_n;
      it.tag    = tag;
      q.push_back(it);
   endtask

   task automatic idle(input string tag);
      step(1, 1, 1, 0, 32'h0, 4'h0, 0, 0, 16'h0, tag);
   endtask

   task automatic clr(input logic [15:0] wd, input string tag);
      step(1, 1, 1, 0, 32'h0, 4'h0, 0, 1, wd, tag);
   endtask

   task automatic set_en(input bit per, input bit se);
      idle("drain");
      idle("drain");
      cmd_per     = per;
      cmd_serr_en = se;
   endtask

   // one-data-phase write: address, data, back to idle
   task automatic txn(input bit ts, input bit bad_a, input bit bad_d,
                      input logic [31:0] a, input string tag);
      step(0, 1, 1, ts, a, 4'h7, bad_a, 0, 16'h0, tag);
      step(1, 0, 0, ts, ~a, 4'h0, bad_d, 0, 16'h0, tag);
      idle(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      n_chk++;
      if ({perr_n, serr_n, stat_det_par, stat_sig_serr} !== 4'b1100) begin
         n_fail++;
         $display("FAIL R11: actual %b%b%b%b expected 1100",
                  perr_n, serr_n, stat_det_par, stat_sig_serr);
      end
      mon_on = 1'b1;

      set_en(1, 1);
      // R1 clean traffic, several patterns
      txn(1, 0, 0, 32'hA5A5_0F0F, "R1");
      txn(1, 0, 0, 32'hFFFF_FFFF, "R1");
      txn(0, 0, 0, 32'h1234_5678, "R1");
      // R4 R3 bad data while target with response on
      txn(1, 0, 1, 32'h0000_0001, "R4");
      idle("R4");
      // R9 clear detected bit
      clr(16'h8000, "R9");
      idle("R9");
      // R2 bad parity on idle and on a wait state is ignored
      step(1, 1, 1, 1, 32'hDEAD_BEEF, 4'h3, 1, 0, 16'h0, "R2");
      step(0, 1, 1, 1, 32'h0000_00F0, 4'h6, 0, 0, 16'h0, "R2");
      step(0, 0, 1, 1, 32'h0F00_0000, 4'h0, 1, 0, 16'h0, "R2");
      step(1, 0, 0, 1, 32'h0000_0F00, 4'h0, 0, 0, 16'h0, "R2");
      idle("R2");
      // R5 not target
      txn(0, 0, 1, 32'h7777_0000, "R5");
      idle("R5");
      // R4 back-to-back errored data phases
      step(0, 1, 1, 1, 32'h4000_0000, 4'h7, 0, 0, 16'h0, "R4");
      step(0, 0, 0, 1, 32'h0000_0011, 4'h0, 1, 0, 16'h0, "R4");
      step(0, 0, 0, 1, 32'h0000_0022, 4'h1, 1, 0, 16'h0, "R4");
      step(1, 0, 0, 1, 32'h0000_0033, 4'h2, 0, 0, 16'h0, "R4");
      idle("R4");
      clr(16'hC000, "R9");
      idle("R9");
      // R6 R7 R8 address error with device not involved
      txn(0, 1, 0, 32'h8000_1234, "R7");
      idle("R7");
      // R9 clear only bit 14, then other bits only
      clr(16'h4000, "R9");
      idle("R9");
      clr(16'h3FFF, "R9");
      idle("R9");
      clr(16'h8000, "R9");
      idle("R9");
      // R7 serr enable off
      set_en(1, 0);
      txn(1, 1, 0, 32'h0101_0101, "R7");
      idle("R7");
      clr(16'h8000, "R9");
      // R6 response off, serr on
      set_en(0, 1);
      txn(0, 1, 0, 32'h0202_0202, "R6");
      idle("R6");
      clr(16'h8000, "R9");
      // R3 data error with response off still sets status
      txn(1, 0, 1, 32'h0303_0303, "R3");
      idle("R3");
      // R10 set and clear on the same edge
      set_en(1, 1);
      clr(16'h8000, "R9");
      step(0, 1, 1, 1, 32'h0404_0404, 4'h7, 0, 0, 16'h0, "R10");
      step(1, 0, 0, 1, 32'h0505_0505, 4'h0, 1, 0, 16'h0, "R10");
      step(1, 1, 1, 0, 32'h0, 4'h0, 0, 1, 16'h8000, "R10");
      idle("R10");
      idle("R10");
      repeat (4) idle("end");
      wait (q.size() == 0);
      @(negedge clk);
      finish_run();
   end

endmodule